// File: doc/BRIEF.md
# Prescaled Timer and Falling-Edge Event Counter

An 8-bit up-counter that takes its count pulses from one of two sources. In timer mode the pulses come from a prescaler that divides the machine-cycle strobe by 32. In event mode the pulses come from falling edges on an asynchronous input pin. The pin is first passed through a two-stage synchronizer. A hold-off window then limits how often events are counted.

Software loads the count register from an accumulator-width bus and reads it back at any time. Three one-cycle command strobes control the block: start timing, start event counting, and stop. When the count rolls over from its all-ones value to zero, the block sets a sticky time-out flag. If the interrupt enable is on, it also emits a one-cycle interrupt request. A test strobe returns the flag and clears it, so software can poll for the time-out.

Top module: `event_timer`

## Requirements
- R1: While reset is held and on the first cycle after it is released, the count reads 00h, the time-out flag is 0 and the interrupt request is 0. The block is stopped, so machine-cycle strobes leave the count at 00h.
- R2: A load strobe writes the load value into the count at the next clock edge. If a count pulse falls in the same cycle, the load wins and the pulse is lost. The count is always visible on the read port.
- R3: After a start-timer command, the count advances by one for every 32 machine-cycle strobes. Clock cycles without the strobe do not advance the prescaler.
- R4: A start-timer command clears the prescaler. The next increment therefore comes exactly 32 strobes after the clock edge that takes the command, even if the timer was already running.
- R5: In event mode, a high-to-low transition on the event pin raises the count on the third clock edge after the pin falls. A low-to-high transition does not count, and the pin may stay at either level for any length of time.
- R6: After an event is counted, falling edges that are detected before 3 further machine-cycle strobes have occurred are ignored.
- R7: After a stop command the count holds its value. A later start resumes counting from the held value.
- R8: A rollover from FFh to 00h sets the time-out flag whatever the interrupt enable is. The flag stays set until it is tested.
- R9: On a rollover taken while the interrupt enable is 1, the interrupt request is 1 for exactly the one cycle that follows the rollover edge. When the enable is 0, the request stays 0.
- R10: The flag output holds the flag's value during the cycle in which the test strobe is high. The flag then reads 0 after the next edge, unless a rollover happens in that same cycle, in which case the flag stays 1.
- R11: When several commands arrive in one cycle, stop outranks start-timer, and start-timer outranks start-event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_en | input | 1 | Machine-cycle strobe |
| ld_en | input | 1 | Load count from ld_data |
| ld_data | input | 8 | Value to load |
| rd_data | output | 8 | Current count |
| go_timer | input | 1 | Start prescaled timing |
| go_event | input | 1 | Start counting pin events |
| halt | input | 1 | Stop counting |
| ext_pin | input | 1 | Asynchronous event input |
| irq_en | input | 1 | Interrupt enable |
| tof_test | input | 1 | Test-and-clear the time-out flag |
| tof | output | 1 | Time-out flag |
| irq | output | 1 | Interrupt request pulse |

## Verification
A load appears on the read port one edge after its strobe. A timer increment appears 32 strobes after the start edge. A pin fall is counted on the third edge after it. The interrupt pulse and the flag both appear on the rollover edge, and a test clears the flag on the following edge. The bench drives every input on the falling clock edge and advances an exact number of edges before each sample. For every count, it checks the value one edge before the due edge (unchanged) and again at the due edge (changed), so an off-by-one latency is caught from either side.

// File: rtl/cet_pkg.sv
package cet_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_TIMER = 2'd1,
        MODE_EVENT = 2'd2
    } run_mode_e;

    typedef struct packed {
        logic halt;
        logic go_tmr;
        logic go_evt;
    } cmd_t;

    // Stop outranks start-timer, which outranks start-event.
    function automatic run_mode_e next_mode(input cmd_t c, input run_mode_e cur);
        if (c.halt)        return MODE_IDLE;
        else if (c.go_tmr) return MODE_TIMER;
        else if (c.go_evt) return MODE_EVENT;
        else               return cur;
    endfunction

endpackage

// File: rtl/cet_prescale.sv
module cet_prescale #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic mc_en,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick = mc_en && !clr && (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            pre_q <= '0;
        else if (mc_en)
            pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
    end
endmodule

// File: rtl/cet_evt_detect.sv
module cet_evt_detect #(
    parameter int GAP = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic armed,
    input  logic clr_gap,
    input  logic mc_en,
    output logic evt
);
    localparam int GW = $clog2(GAP + 1);

    logic          s1_q, s2_q, prev_q;
    logic [GW-1:0] gap_q;
    logic          fall;

    assign fall = prev_q && !s2_q;
    assign evt  = armed && fall && (gap_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= pin;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_gap)
            gap_q <= '0;
        else if (evt)
            gap_q <= GW'(GAP);
        else if (mc_en && gap_q != '0)
            gap_q <= gap_q - GW'(1);
    end
endmodule

// File: rtl/cet_count_core.sv
module cet_count_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    input  logic         flag_clr,
    input  logic         irq_en,
    output logic [W-1:0] cnt,
    output logic         flag,
    output logic         irq,
    output logic         wrap
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         flag_q, irq_q;

    assign wrap = inc && !ld && (cnt_q == ALL1);
    assign cnt  = cnt_q;
    assign flag = flag_q;
    assign irq  = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (ld)
                cnt_q <= ld_val;
            else if (inc)
                cnt_q <= cnt_q + W'(1);

            if (wrap)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;

            irq_q <= wrap && irq_en;
        end
    end
endmodule

// File: rtl/event_timer.sv
module event_timer #(
    parameter int CNT_W   = 8,
    parameter int PRE_DIV = 32,
    parameter int EVT_GAP = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mc_en,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic             go_timer,
    input  logic             go_event,
    input  logic             halt,
    input  logic             ext_pin,
    input  logic             irq_en,
    input  logic             tof_test,
    output logic             tof,
    output logic             irq
);
    import cet_pkg::*;

    cmd_t      cmd;
    run_mode_e mode_q;
    logic      tmr_start, evt_start;
    logic      pre_tick, evt_tick, inc, wrap;
    logic      run_idle;

    assign cmd       = '{halt: halt, go_tmr: go_timer, go_evt: go_event};
    assign tmr_start = go_timer && !halt;
    assign evt_start = go_event && !go_timer && !halt;
    assign run_idle  = (mode_q == MODE_IDLE);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_IDLE;
        else
            mode_q <= next_mode(cmd, mode_q);
    end

    cet_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_start),
        .mc_en (mc_en),
        .tick  (pre_tick)
    );

    cet_evt_detect #(.GAP(EVT_GAP)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .pin     (ext_pin),
        .armed   (mode_q == MODE_EVENT),
        .clr_gap (evt_start),
        .mc_en   (mc_en),
        .evt     (evt_tick)
    );

    assign inc = ((mode_q == MODE_TIMER) && pre_tick) ||
                 ((mode_q == MODE_EVENT) && evt_tick);

    cet_count_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .ld       (ld_en),
        .ld_val   (ld_data),
        .inc      (inc),
        .flag_clr (tof_test),
        .irq_en   (irq_en),
        .cnt      (rd_data),
        .flag     (tof),
        .irq      (irq),
        .wrap     (wrap)
    );
endmodule

// File: rtl/event_timer_checks.sv
module event_timer_checks #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] cnt,
    input logic         tof,
    input logic         irq,
    input logic         irq_en,
    input logic         ld,
    input logic         tof_test,
    input logic         idle,
    input logic         wrap
);
    // R9: a request follows only an all-ones count with the enable set
    assert_irq_after_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(cnt) == {W{1'b1}}) && $past(irq_en));

    // R8: the flag only rises on a rollover to zero
    assert_flag_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(tof) |-> (cnt == '0));

    // R7: a stopped counter with no load keeps its value
    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (idle && !ld) |=> $stable(cnt));

    // R3: without a load the count moves by at most one step
    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(ld) && (cnt != $past(cnt))) |-> (cnt == W'($past(cnt) + W'(1))));

    // R10: a test with no colliding rollover clears the flag
    assert_test_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (tof_test && !wrap) |=> !tof);
endmodule

bind event_timer event_timer_checks #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt      (rd_data),
    .tof      (tof),
    .irq      (irq),
    .irq_en   (irq_en),
    .ld       (ld_en),
    .tof_test (tof_test),
    .idle     (run_idle),
    .wrap     (wrap)
);

// File: tb/event_timer_bench.sv
module event_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mc_en = 1'b0, ld_en = 1'b0, go_timer = 1'b0, go_event = 1'b0;
    logic       halt = 1'b0, ext_pin = 1'b1, irq_en = 1'b0, tof_test = 1'b0;
    logic [7:0] ld_data = 8'h00;
    logic [7:0] rd_data;
    logic       tof, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    event_timer u_event_timer (
        .clk(clk), .rst(rst), .mc_en(mc_en), .ld_en(ld_en), .ld_data(ld_data),
        .rd_data(rd_data), .go_timer(go_timer), .go_event(go_event), .halt(halt),
        .ext_pin(ext_pin), .irq_en(irq_en), .tof_test(tof_test), .tof(tof), .irq(irq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic pulse_cmd(input bit t, input bit e, input bit h);
        go_timer = t; go_event = e; halt = h;
        step(1);
        go_timer = 0; go_event = 0; halt = 0;
    endtask

    task automatic load(input logic [7:0] v);
        ld_en = 1; ld_data = v;
        step(1);
        ld_en = 0;
    endtask

    task automatic t_reset;
        step(1);
        chk("R1 count", rd_data, 8'h00);
        chk("R1 flag", tof, 0);
        chk("R1 irq", irq, 0);
        rst = 0;
        step(1);
        chk("R1 count after release", rd_data, 8'h00);
        mc_en = 1;
        step(40);
        chk("R1 idle no count", rd_data, 8'h00);
    endtask

    task automatic t_load;
        load(8'hA5);
        chk("R2 load", rd_data, 8'hA5);
        step(10);
        chk("R2 load held", rd_data, 8'hA5);
    endtask

    task automatic t_timer;
        load(8'h10);
        pulse_cmd(1, 0, 0);
        step(31);
        chk("R3 before 32 strobes", rd_data, 8'h10);
        step(1);
        chk("R3 after 32 strobes", rd_data, 8'h11);
        step(16);
        mc_en = 0;
        step(50);
        mc_en = 1;
        step(15);
        chk("R3 gaps ignored", rd_data, 8'h11);
        step(1);
        chk("R3 32nd strobe", rd_data, 8'h12);
    endtask

    task automatic t_stop;
        pulse_cmd(0, 0, 1);
        step(100);
        chk("R7 held while stopped", rd_data, 8'h12);
        pulse_cmd(1, 0, 0);
        step(32);
        chk("R7 resumes from held", rd_data, 8'h13);
    endtask

    task automatic t_restart;
        step(20);
        pulse_cmd(1, 0, 0);
        step(31);
        chk("R4 prescaler cleared", rd_data, 8'h13);
        step(1);
        chk("R4 tick after restart", rd_data, 8'h14);
        step(31);
        ld_en = 1; ld_data = 8'h55;
        step(1);
        ld_en = 0;
        chk("R2 load beats increment", rd_data, 8'h55);
        step(31);
        chk("R2 no late increment", rd_data, 8'h55);
        step(1);
        chk("R2 next tick", rd_data, 8'h56);
        pulse_cmd(0, 0, 1);
    endtask

    task automatic t_overflow_irq;
        irq_en = 1;
        load(8'hFF);
        pulse_cmd(1, 0, 0);
        step(31);
        chk("R9 no early irq", irq, 0);
        step(1);
        chk("R8 wrap to zero", rd_data, 8'h00);
        chk("R8 flag set", tof, 1);
        chk("R9 irq pulse", irq, 1);
        step(1);
        chk("R9 irq one cycle", irq, 0);
        chk("R8 flag sticky", tof, 1);
        pulse_cmd(0, 0, 1);
    endtask

    task automatic t_test_clear;
        tof_test = 1;
        #1;
        chk("R10 test returns flag", tof, 1);
        step(1);
        tof_test = 0;
        chk("R10 flag cleared", tof, 0);
    endtask

    task automatic t_masked;
        irq_en = 0;
        load(8'hFF);
        pulse_cmd(1, 0, 0);
        step(32);
        chk("R8 flag set with irq off", tof, 1);
        chk("R9 irq masked", irq, 0);
        step(20);
        chk("R8 flag stays", tof, 1);
        chk("R9 irq still masked", irq, 0);
        pulse_cmd(0, 0, 1);
        load(8'hFF);
        pulse_cmd(1, 0, 0);
        step(31);
        tof_test = 1;
        step(1);
        tof_test = 0;
        chk("R10 collision count", rd_data, 8'h00);
        chk("R10 set wins", tof, 1);
        pulse_cmd(0, 0, 1);
        tof_test = 1;
        step(1);
        tof_test = 0;
        chk("R10 later clear", tof, 0);
    endtask

    task automatic t_priority;
        load(8'h20);
        pulse_cmd(1, 0, 1);
        step(80);
        chk("R11 stop beats start", rd_data, 8'h20);
        pulse_cmd(1, 1, 0);
        ext_pin = 0; step(5);
        ext_pin = 1; step(5);
        step(21);
        chk("R11 timer beats event", rd_data, 8'h20);
        step(1);
        chk("R11 timer running", rd_data, 8'h21);
        pulse_cmd(0, 0, 1);
    endtask

    task automatic t_event;
        load(8'h00);
        pulse_cmd(0, 1, 0);
        step(5);
        ext_pin = 0;
        step(2);
        chk("R5 not before third edge", rd_data, 8'h00);
        step(1);
        chk("R5 counted on third edge", rd_data, 8'h01);
        step(300);
        chk("R5 long low counts once", rd_data, 8'h01);
        ext_pin = 1;
        step(10);
        chk("R5 rise ignored", rd_data, 8'h01);
    endtask

    task automatic t_event_rate;
        ext_pin = 0; step(1);
        ext_pin = 1; step(1);
        ext_pin = 0; step(10);
        chk("R6 fast second edge dropped", rd_data, 8'h02);
        ext_pin = 1; step(5);
        ext_pin = 0; step(3);
        chk("R6 spaced edge counted", rd_data, 8'h03);
        pulse_cmd(0, 0, 1);
        ext_pin = 1; step(5);
        ext_pin = 0; step(10);
        chk("R7 stopped ignores pin", rd_data, 8'h03);
    endtask

    initial begin
        t_reset;
        t_load;
        t_timer;
        t_stop;
        t_restart;
        t_overflow_irq;
        t_test_clear;
        t_masked;
        t_priority;
        t_event;
        t_event_rate;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule